// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer that software controls through a small register bus. It is driven mainly by writing 16-bit magic values into a key word. One value starts the watchdog, and nothing can stop it after that except a hardware reset. A second value reloads the counter, and software must write it periodically to show it is alive. A third value opens the divider and reload registers for writing. A 12-bit down-counter advances on a slow watchdog tick, which is first divided by a power-of-two prescaler. When the counter expires without having been reloaded, the block raises a single-cycle reset request, reloads itself and starts counting again.

The slow clock is presented to the block as a one-cycle enable, `tick_i`, in the bus clock domain. A change to the divider or the reload value reaches the counter only after a fixed number of ticks. Until then, a busy flag for that field stays high in the status word, so software can poll for completion. A window word is provided as plain read/write storage and has no effect on the counter.

Top module: `wdg_keyed`

## Requirements
- R1: After reset the divider code reads 0, the reload value reads 0xFFF, the status word reads 0, the window word reads 0xFFF, and `rst_req_o` is low.
- R2: Writing the full 32-bit word 0x0000CCCC to word 0 (byte offset 0x00) starts the watchdog. Before that write no reset request is raised. After it, no key value stops the counter.
- R3: Writing 0x0000AAAA to word 0 loads the counter with the active reload value and restarts the prescaler phase from zero.
- R4: Once started, the counter expires (R+1)·4·2^k ticks after the last reload, where R is the active reload value and k is the active divider code. Expiry drives `rst_req_o` high for exactly one clock and reloads the counter, so the period then repeats.
- R5: Writing 0x00005555 to word 0 opens word 1 (divider) and word 2 (reload) for writing. Writing 0x00000000 closes them. Any key value other than 0x5555, 0x0000, 0xAAAA and 0xCCCC also closes them, while 0xAAAA and 0xCCCC leave the lock state as it is. Writes to word 1 or word 2 while they are closed are ignored.
- R6: The divider code is taken from bits [2:0] of word 1, and a code above 6 is stored as 6. The reload value is taken from bits [11:0] of word 2.
- R7: In the status word (word 3, byte 0x0C), bit 0 shows a divider update in flight and bit 1 shows a reload update in flight. Each bit rises on an accepted write and falls on the 3rd tick after the most recent such write. The counter uses the new value only from that point on.
- R8: Word 4 (byte 0x10) is a 12-bit read/write word that is always writable and has no effect on timing.
- R9: A reload key written in the same cycle as an expiry step wins: no reset request is raised, and the counter restarts from the reload value.
- R10: Words 1 and 2 read back the most recently accepted write, even while its update is still in flight. Word 0 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle watchdog tick enable |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_word | input | 3 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| rst_req_o | output | 1 | One-cycle reset request on expiry |

## Verification
Two collisions can happen in the same cycle. One is a reload key arriving on the tick that would otherwise expire the counter. The other is a configuration write arriving while a tick is moving an earlier update toward the counter. The first case is provoked by programming a four-tick period, then issuing a second reload key exactly four ticks after the first. The result is judged by checking that `rst_req_o` stays low and that the next request comes a full period later. The second case is judged by showing that a reload issued while the busy flag is still high times out with the old value, and that the following period uses the new one.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic [15:0] KEY_START = 16'hCCCC;
  localparam logic [15:0] KEY_KICK  = 16'hAAAA;
  localparam logic [15:0] KEY_OPEN  = 16'h5555;
  localparam logic [15:0] KEY_SHUT  = 16'h0000;

  localparam logic [2:0] W_KEY  = 3'd0;
  localparam logic [2:0] W_DIV  = 3'd1;
  localparam logic [2:0] W_RLD  = 3'd2;
  localparam logic [2:0] W_STAT = 3'd3;
  localparam logic [2:0] W_WIN  = 3'd4;
endpackage

// File: rtl/wdg_keyunit.sv
module wdg_keyunit
  import wdg_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    word,
  input  logic [31:0]   wdata,
  output logic          start_p,
  output logic          kick_p,
  output logic          cfg_open,
  output logic          div_we,
  output logic          rld_we,
  output logic [CW-1:0] win_q
);
  logic          open_q, open_d;
  logic [CW-1:0] win_d;
  logic          key_wr, win_wr;

  always_comb begin
    key_wr  = wr_en && (word == W_KEY);
    win_wr  = wr_en && (word == W_WIN);
    start_p = key_wr && (wdata == {16'h0, KEY_START});
    kick_p  = key_wr && (wdata == {16'h0, KEY_KICK});
    div_we  = wr_en && (word == W_DIV) && open_q;
    rld_we  = wr_en && (word == W_RLD) && open_q;
    open_d  = open_q;
    if (key_wr) begin
      if (wdata == {16'h0, KEY_OPEN}) open_d = 1'b1;
      else if (!start_p && !kick_p)   open_d = 1'b0;
    end
    win_d = win_wr ? wdata[CW-1:0] : win_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      win_q  <= '1;
    end else begin
      if (key_wr) open_q <= open_d;
      if (win_wr) win_q  <= win_d;
    end
  end

  assign cfg_open = open_q;
endmodule

// File: rtl/wdg_cfg_cross.sv
module wdg_cfg_cross #(
  parameter int unsigned   W          = 3,
  parameter int unsigned   SYNC_TICKS = 3,
  parameter logic [W-1:0]  RST_VAL    = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         we,
  input  logic [W-1:0] wval,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active,
  output logic         busy
);
  localparam int unsigned SC_W = $clog2(SYNC_TICKS + 1);

  logic [W-1:0]    sh_q, sh_d, act_q, act_d;
  logic [SC_W-1:0] cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    act_d = act_q;
    cnt_d = cnt_q;
    if (we) begin
      sh_d  = wval;
      cnt_d = SC_W'(SYNC_TICKS);
    end else if (tick && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == SC_W'(1)) act_d = sh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= RST_VAL;
      act_q <= RST_VAL;
      cnt_q <= '0;
    end else begin
      if (we) sh_q <= sh_d;
      if (we || tick) begin
        act_q <= act_d;
        cnt_q <= cnt_d;
      end
    end
  end

  assign shadow = sh_q;
  assign active = act_q;
  assign busy   = (cnt_q != '0);
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
  parameter int unsigned CW   = 12,
  parameter int unsigned DIVW = 3,
  parameter int unsigned PDW  = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            start_p,
  input  logic            kick_p,
  input  logic [DIVW-1:0] div_code,
  input  logic [CW-1:0]   rld_val,
  output logic            running,
  output logic            rst_req
);
  logic           run_q, run_d, req_q, req_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [PDW-1:0] pre_q, pre_d, pre_lim;

  always_comb begin
    pre_lim = (PDW'(4) << div_code) - PDW'(1);
    run_d   = run_q | start_p;
    cnt_d   = cnt_q;
    pre_d   = pre_q;
    req_d   = 1'b0;
    if (start_p || kick_p) begin
      cnt_d = rld_val;
      pre_d = '0;
    end else if (run_q && tick) begin
      if (pre_q >= pre_lim) begin
        pre_d = '0;
        if (cnt_q == '0) begin
          req_d = 1'b1;
          cnt_d = rld_val;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      req_q <= 1'b0;
      cnt_q <= '1;
      pre_q <= '0;
    end else begin
      run_q <= run_d;
      req_q <= req_d;
      if (start_p || kick_p || (run_q && tick)) begin
        cnt_q <= cnt_d;
        pre_q <= pre_d;
      end
    end
  end

  assign running = run_q;
  assign rst_req = req_q;
endmodule

// File: rtl/wdg_keyed.sv
module wdg_keyed
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W      = 12,
  parameter bit          WIDE_DIV   = 1'b0,
  parameter int unsigned SYNC_TICKS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [2:0]  bus_word,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        rst_req_o
);
  localparam int unsigned DIV_MAX = WIDE_DIV ? 8 : 6;
  localparam int unsigned DIV_W   = $clog2(DIV_MAX + 1);
  localparam int unsigned PD_W    = DIV_MAX + 3;

  logic             start_p, kick_p, cfg_open, div_we, rld_we, running;
  logic [CNT_W-1:0] win_q, rld_shadow, rld_active;
  logic [DIV_W-1:0] div_in, div_shadow, div_active;
  logic             div_busy, rld_busy;

  wdg_keyunit #(.CW(CNT_W)) u_keys (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_en && bus_we), .word(bus_word),
    .wdata(bus_wdata), .start_p(start_p), .kick_p(kick_p),
    .cfg_open(cfg_open), .div_we(div_we), .rld_we(rld_we), .win_q(win_q)
  );

  generate
    if ((2 ** DIV_W) - 1 > DIV_MAX) begin : g_clamp
      assign div_in = (bus_wdata[DIV_W-1:0] > DIV_W'(DIV_MAX)) ?
                      DIV_W'(DIV_MAX) : bus_wdata[DIV_W-1:0];
    end else begin : g_pass
      assign div_in = bus_wdata[DIV_W-1:0];
    end
  endgenerate

  wdg_cfg_cross #(.W(DIV_W), .SYNC_TICKS(SYNC_TICKS), .RST_VAL('0)) u_div_x (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .we(div_we), .wval(div_in),
    .shadow(div_shadow), .active(div_active), .busy(div_busy)
  );

  wdg_cfg_cross #(.W(CNT_W), .SYNC_TICKS(SYNC_TICKS), .RST_VAL('1)) u_rld_x (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .we(rld_we),
    .wval(bus_wdata[CNT_W-1:0]),
    .shadow(rld_shadow), .active(rld_active), .busy(rld_busy)
  );

  wdg_countdown #(.CW(CNT_W), .DIVW(DIV_W), .PDW(PD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .start_p(start_p),
    .kick_p(kick_p), .div_code(div_active), .rld_val(rld_active),
    .running(running), .rst_req(rst_req_o)
  );

  always_comb begin
    case (bus_word)
      W_DIV:   bus_rdata = 32'(div_shadow);
      W_RLD:   bus_rdata = 32'(rld_shadow);
      W_STAT:  bus_rdata = {30'h0, rld_busy, div_busy};
      W_WIN:   bus_rdata = 32'(win_q);
      default: bus_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/wdg_keyed_chk.sv
module wdg_keyed_chk #(
  parameter int unsigned DIV_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             rst_req_o,
  input logic             running,
  input logic             start_p,
  input logic             kick_p,
  input logic             cfg_open,
  input logic             div_we,
  input logic             div_busy,
  input logic [DIV_W-1:0] div_shadow
);
  p_req_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  p_req_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> running);

  p_run_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);

  p_kick_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_p || start_p) |=> !rst_req_o);

  p_locked_div_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> $stable(div_shadow));

  p_busy_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    div_we |=> div_busy);

  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (div_busy && !tick_i) |=> div_busy);
endmodule

bind wdg_keyed wdg_keyed_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rst_req_o(rst_req_o),
  .running(running), .start_p(start_p), .kick_p(kick_p),
  .cfg_open(cfg_open), .div_we(div_we), .div_busy(div_busy),
  .div_shadow(div_shadow)
);

// File: tb/wdg_keyed_bench.sv
module wdg_keyed_bench;
  logic        clk = 1'b0;
  logic        rst_n, tick_i, bus_en, bus_we, rst_req_o;
  logic [2:0]  bus_word;
  logic [31:0] bus_wdata, bus_rdata;
  int vecs = 0;
  int errs = 0;

  always #5 clk = ~clk;

  wdg_keyed u_wdg_keyed (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_en(bus_en),
    .bus_we(bus_we), .bus_word(bus_word), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_req_o(rst_req_o)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] w, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_word = w; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] w, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_word = w;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic time_to_req(output int k);
    k = 0;
    while (rst_req_o !== 1'b1 && k < 20000) begin
      @(posedge clk); @(negedge clk); k++;
    end
  endtask

  task automatic next_req(input string tag, output int k);
    int m;
    edges(1);
    chk({tag, " pulse width"}, rst_req_o, 0);
    time_to_req(m);
    k = m + 1;
  endtask

  task automatic settle();
    logic [31:0] s;
    for (int i = 0; i < 100; i++) begin
      rd(3'd3, s);
      if (s[1:0] == 2'b00) break;
      edges(1);
    end
  endtask

  task automatic cfg(input int dv, input int rl);
    wr(3'd0, 32'h5555); wr(3'd1, dv); wr(3'd2, rl); settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int k, seen;
    rst_n = 1'b0; tick_i = 1'b0; bus_en = 1'b0; bus_we = 1'b0;
    bus_word = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(3'd1, d); chk("R1 divider", d, 0);
    rd(3'd2, d); chk("R1 reload", d, 32'hFFF);
    rd(3'd3, d); chk("R1 status", d, 0);
    rd(3'd4, d); chk("R1 window", d, 32'hFFF);
    rd(3'd0, d); chk("R10 key reads zero", d, 0);
    chk("R1 request", rst_req_o, 0);

    // R2 nothing before start
    tick_i = 1'b1;
    cfg(0, 2);
    seen = 0;
    for (int i = 0; i < 200; i++) begin edges(1); if (rst_req_o) seen++; end
    chk("R2 idle before start", seen, 0);
    wr(3'd0, 32'hCCCC);
    time_to_req(k); chk("R2 first expiry", k, 12);
    next_req("R4", k); chk("R4 repeat period", k, 12);

    // R2 no key stops it
    wr(3'd0, 32'hAAAA); wr(3'd0, 32'h0000); wr(3'd0, 32'h1234);
    time_to_req(k); chk("R2 still running", k, 10);

    // R5 locked writes ignored
    wr(3'd1, 3);
    rd(3'd1, d); chk("R5 locked divider", d, 0);
    rd(3'd3, d); chk("R5 locked status", d, 0);
    wr(3'd0, 32'h5555); wr(3'd0, 32'hBEEF); wr(3'd2, 7);
    rd(3'd2, d); chk("R5 odd key relocks", d, 2);
    wr(3'd0, 32'h5555); wr(3'd0, 32'hAAAA); wr(3'd0, 32'hCCCC); wr(3'd2, 9);
    rd(3'd2, d); chk("R5 run keys keep open", d, 9);
    wr(3'd2, 2); settle();

    // R6 field and clamp
    wr(3'd1, 7);            rd(3'd1, d); chk("R6 clamp", d, 6);
    wr(3'd1, 32'hFFFFFFF1); rd(3'd1, d); chk("R6 field", d, 1);
    wr(3'd2, 32'hABCDE002); rd(3'd2, d); chk("R6 reload field", d, 2);
    wr(3'd1, 0); settle();

    // R8 window
    wr(3'd4, 32'h123); rd(3'd4, d); chk("R8 window", d, 32'h123);
    wr(3'd0, 32'h0000);
    wr(3'd4, 32'h0A5); rd(3'd4, d); chk("R8 window when closed", d, 32'h0A5);
    wr(3'd0, 32'hAAAA); time_to_req(k); chk("R8 no timing effect", k, 12);

    // R7 busy flags and delayed effect
    tick_i = 1'b0;
    wr(3'd0, 32'h5555); wr(3'd2, 9);
    rd(3'd3, d); chk("R7 reload busy", d, 2);
    rd(3'd2, d); chk("R10 readback while busy", d, 9);
    edges(10);
    rd(3'd3, d); chk("R7 no tick holds busy", d, 2);
    wr(3'd0, 32'hAAAA);
    tick_i = 1'b1;
    edges(2); rd(3'd3, d); chk("R7 busy after 2 ticks", d, 2);
    edges(1); rd(3'd3, d); chk("R7 clear after 3 ticks", d, 0);
    time_to_req(k); chk("R7 old value in force", k, 9);
    next_req("R7", k); chk("R7 new value period", k, 40);
    tick_i = 1'b0;
    wr(3'd1, 1); rd(3'd3, d); chk("R7 divider busy", d, 1);
    tick_i = 1'b1;
    edges(3); rd(3'd3, d); chk("R7 divider clear", d, 0);

    // R3 reload restarts prescaler phase
    cfg(2, 1);
    wr(3'd0, 32'hAAAA); edges(10); wr(3'd0, 32'hAAAA);
    time_to_req(k); chk("R3 phase restart", k, 32);

    // R9 reload key on the expiry tick
    cfg(0, 0);
    wr(3'd0, 32'hAAAA); edges(3);
    chk("R9 before collision", rst_req_o, 0);
    wr(3'd0, 32'hAAAA);
    chk("R9 collision no request", rst_req_o, 0);
    time_to_req(k); chk("R9 full period after", k, 4);

    // R4 sweep over divider codes and reload values
    for (int dv = 0; dv <= 6; dv++) begin
      for (int j = 0; j < 4; j++) begin
        int rl;
        rl = (j == 3) ? 7 : j;
        cfg(dv, rl);
        wr(3'd0, 32'hAAAA);
        time_to_req(k); chk($sformatf("R4 k=%0d r=%0d", dv, rl), k, (rl + 1) * (4 << dv));
        next_req("R4", k); chk($sformatf("R4 repeat k=%0d r=%0d", dv, rl), k, (rl + 1) * (4 << dv));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule